// File: doc/BRIEF.md
# Time-of-Day Counter with Periodic Drift Correction

This block keeps a running time of day as seconds, nanoseconds and a 16-bit binary fraction of a nanosecond. Every clock cycle the time moves forward by a programmed clock period, given as whole nanoseconds plus a fraction in units of 1/65536 ns. A period such as 6.4 ns has no exact 16-bit fraction, so each cycle loses a small remainder. Left alone, that loss adds up to close to a microsecond every second.

To cancel that loss, a second cycle counter runs beside the time counter. Once per programmed interval it adds a small correction value of whole and fractional nanoseconds. The correction is added on top of that cycle's normal period step. Software programs the period, the correction value and the interval through a small word-addressed register port. Through the same port it can also load a new absolute time.

The time outputs are registered. A write to any register takes effect at the next rising clock edge.

Top module: `tod_drift_counter`

## Requirements
- R1: After reset the time is 0 s, 0 ns, fraction 0. The period, correction and interval registers read as zero. With a zero period and no correction firing, the time does not change.
- R2: The period register sits at byte offset 0x10, with the fraction in bits 15:0 and whole nanoseconds in bits 19:16. Bits above 19 read as zero. On every cycle without a time load, the time advances by the current period.
- R3: The correction register sits at offset 0x1C, with the fraction in bits 15:0 and whole nanoseconds in bits 19:16. Bits above 19 read as zero and are dropped on a write.
- R4: The interval register sits at offset 0x20 and holds a 16-bit cycle count in bits 15:0. Higher bits read as zero. An interval of zero means no correction is ever added.
- R5: With an interval of N (N > 0), the correction is added on every N-th cycle, counted from the last interval write or time load. It is added in that cycle together with the period.
- R6: Any write to the interval register restarts the cycle count from zero, even when the value written is unchanged.
- R7: When the fractional sum overflows 16 bits, the carry (up to 2) goes into the nanoseconds.
- R8: When the nanoseconds reach 1,000,000,000 or more, one billion is subtracted and the seconds go up by one. This also holds when the period and the correction land on the same cycle. Seconds never step by more than one per cycle outside a load.
- R9: A time load uses staging registers: seconds bits 47:32 at 0x00 (bits 15:0), seconds bits 31:0 at 0x04, and the fraction at 0x0C (bits 15:0). Writing nanoseconds to 0x08 (bits 29:0) commits the load. The loaded time appears after that clock edge, replaces that cycle's increment, and clears the interval count. The staging and load offsets, and any other unlisted offset, read as zero.
- R10: With a period of 6 ns plus 0x6666, a correction of 0 ns plus 0x0002, and an interval of 5, the time gains exactly 32 ns with a zero fraction every 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tod_sec | output | 48 | Seconds |
| tod_ns | output | 30 | Nanoseconds |
| tod_fns | output | 16 | Fractional nanoseconds (1/65536 ns) |

## Verification
Several properties are checked on every cycle:
- A zero interval never fires the correction.
- Firings are never back to back when the interval is above one.
- An interval write or a time load leaves the cycle count at zero.
- A committed load shows the written nanoseconds on the next cycle.
- Seconds step by at most one per cycle.
- Nanoseconds stay below one billion once they start there.
- The time holds still when nothing is added.

Only the scenarios in the bench can show the exact sums:
- The carries out of the fraction.
- The cycle on which the first correction lands after a restart.
- The zero-drift result of the 6.4 ns setting.
- The masking of the upper register bits on read back.

// File: rtl/tod_pkg.sv
package tod_pkg;

   // Register byte offsets; the correction and interval offsets are fixed
   localparam logic [7:0] OFS_SEC_HI = 8'h00;
   localparam logic [7:0] OFS_SEC_LO = 8'h04;
   localparam logic [7:0] OFS_NS_GO  = 8'h08;
   localparam logic [7:0] OFS_FNS    = 8'h0C;
   localparam logic [7:0] OFS_PERIOD = 8'h10;
   localparam logic [7:0] OFS_DRIFT  = 8'h1C;
   localparam logic [7:0] OFS_RATE   = 8'h20;

   localparam int unsigned NS_PER_SEC = 1_000_000_000;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SEC_HI,
      SEL_SEC_LO,
      SEL_NS_GO,
      SEL_FNS,
      SEL_PERIOD,
      SEL_DRIFT,
      SEL_RATE
   } reg_sel_e;

endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
   import tod_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int SEC_W    = 48,
   parameter int NS_W     = 30,
   parameter int FNS_W    = 16,
   parameter int PER_NS_W = 4,
   parameter int RATE_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic [PER_NS_W-1:0] per_ns,
   output logic [FNS_W-1:0]    per_fns,
   output logic [PER_NS_W-1:0] adj_ns,
   output logic [FNS_W-1:0]    adj_fns,
   output logic [RATE_W-1:0]   rate,
   output logic                rate_wr,
   output logic                ld_commit,
   output logic [SEC_W-1:0]    ld_sec,
   output logic [NS_W-1:0]     ld_ns,
   output logic [FNS_W-1:0]    ld_fns
);

   localparam int SEC_HI_W = SEC_W - DATA_W;
   localparam int PAIR_W   = FNS_W + PER_NS_W;

   reg_sel_e            sel;
   logic [SEC_HI_W-1:0] stg_hi;
   logic [DATA_W-1:0]   stg_lo;
   logic [FNS_W-1:0]    stg_fns;

   always_comb begin
      if      (addr == ADDR_W'(OFS_SEC_HI)) sel = SEL_SEC_HI;
      else if (addr == ADDR_W'(OFS_SEC_LO)) sel = SEL_SEC_LO;
      else if (addr == ADDR_W'(OFS_NS_GO))  sel = SEL_NS_GO;
      else if (addr == ADDR_W'(OFS_FNS))    sel = SEL_FNS;
      else if (addr == ADDR_W'(OFS_PERIOD)) sel = SEL_PERIOD;
      else if (addr == ADDR_W'(OFS_DRIFT))  sel = SEL_DRIFT;
      else if (addr == ADDR_W'(OFS_RATE))   sel = SEL_RATE;
      else                                  sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_ns  <= '0;
         per_fns <= '0;
         adj_ns  <= '0;
         adj_fns <= '0;
         rate    <= '0;
         stg_hi  <= '0;
         stg_lo  <= '0;
         stg_fns <= '0;
      end else if (wr_en) begin
         unique case (sel)
            SEL_SEC_HI: stg_hi  <= wdata[SEC_HI_W-1:0];
            SEL_SEC_LO: stg_lo  <= wdata;
            SEL_FNS:    stg_fns <= wdata[FNS_W-1:0];
            SEL_PERIOD: {per_ns, per_fns} <= wdata[PAIR_W-1:0];
            SEL_DRIFT:  {adj_ns, adj_fns} <= wdata[PAIR_W-1:0];
            SEL_RATE:   rate    <= wdata[RATE_W-1:0];
            default: ;
         endcase
      end
   end

   assign rate_wr   = wr_en && (sel == SEL_RATE);
   assign ld_commit = wr_en && (sel == SEL_NS_GO);
   assign ld_sec    = {stg_hi, stg_lo};
   assign ld_ns     = wdata[NS_W-1:0];
   assign ld_fns    = stg_fns;

   always_comb begin
      unique case (sel)
         SEL_PERIOD: rdata = DATA_W'({per_ns, per_fns});
         SEL_DRIFT:  rdata = DATA_W'({adj_ns, adj_fns});
         SEL_RATE:   rdata = DATA_W'(rate);
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/tod_interval_timer.sv
module tod_interval_timer #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic              restart,
   output logic              fire,
   output logic [RATE_W-1:0] cnt
);

   assign fire = (rate != '0) && (cnt == rate - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (restart)                cnt <= '0;
      else if (rate == '0 || fire)     cnt <= '0;
      else                             cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/tod_accum.sv
module tod_accum
   import tod_pkg::*;
#(
   parameter int SEC_W       = 48,
   parameter int NS_W        = 30,
   parameter int FNS_W       = 16,
   parameter int PER_NS_W    = 4,
   parameter bit NS_ROLLOVER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SEC_W-1:0]    ld_sec,
   input  logic [NS_W-1:0]     ld_ns,
   input  logic [FNS_W-1:0]    ld_fns,
   input  logic [PER_NS_W-1:0] per_ns,
   input  logic [FNS_W-1:0]    per_fns,
   input  logic [PER_NS_W-1:0] adj_ns,
   input  logic [FNS_W-1:0]    adj_fns,
   input  logic                fire,
   output logic [SEC_W-1:0]    sec,
   output logic [NS_W-1:0]     ns,
   output logic [FNS_W-1:0]    fns
);

   localparam int FS_W = FNS_W + 2;
   localparam int NX_W = NS_W + 1;

   logic [FS_W-1:0]  fns_sum;
   logic [NX_W-1:0]  ns_sum;
   logic [NS_W-1:0]  ns_next;
   logic             wrap;

   always_comb begin
      fns_sum = FS_W'(fns) + FS_W'(per_fns) + (fire ? FS_W'(adj_fns) : '0);
      ns_sum  = NX_W'(ns) + NX_W'(per_ns) + (fire ? NX_W'(adj_ns) : '0)
              + NX_W'(fns_sum[FS_W-1:FNS_W]);
   end

   generate
      if (NS_ROLLOVER) begin : g_decimal
         localparam logic [NX_W-1:0] BILLION = NX_W'(NS_PER_SEC);
         assign wrap    = (ns_sum >= BILLION);
         assign ns_next = wrap ? NS_W'(ns_sum - BILLION) : ns_sum[NS_W-1:0];
      end else begin : g_binary
         assign wrap    = ns_sum[NS_W];
         assign ns_next = ns_sum[NS_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec <= '0;
         ns  <= '0;
         fns <= '0;
      end else if (load) begin
         sec <= ld_sec;
         ns  <= ld_ns;
         fns <= ld_fns;
      end else begin
         sec <= sec + SEC_W'(wrap);
         ns  <= ns_next;
         fns <= fns_sum[FNS_W-1:0];
      end
   end

endmodule

// File: rtl/tod_drift_counter.sv
module tod_drift_counter #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 32,
   parameter int SEC_W       = 48,
   parameter int NS_W        = 30,
   parameter int FNS_W       = 16,
   parameter int PER_NS_W    = 4,
   parameter int RATE_W      = 16,
   parameter bit NS_ROLLOVER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_ns,
   output logic [FNS_W-1:0]  tod_fns
);

   generate
      if (SEC_W <= DATA_W || SEC_W > 2 * DATA_W) begin : g_bad_sec
         $error("SEC_W must exceed DATA_W and fit in two data words");
      end
      if (FNS_W + PER_NS_W > DATA_W || RATE_W > DATA_W || NS_W > DATA_W) begin : g_bad_fields
         $error("register fields do not fit in DATA_W");
      end
      if (NS_ROLLOVER && NS_W < 30) begin : g_bad_ns
         $error("decimal rollover needs NS_W of at least 30");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   logic [PER_NS_W-1:0] per_ns;
   logic [FNS_W-1:0]    per_fns;
   logic [PER_NS_W-1:0] adj_ns;
   logic [FNS_W-1:0]    adj_fns;
   logic [RATE_W-1:0]   rate;
   logic [RATE_W-1:0]   cnt;
   logic                rate_wr;
   logic                ld_commit;
   logic                fire;
   logic [SEC_W-1:0]    ld_sec;
   logic [NS_W-1:0]     ld_ns;
   logic [FNS_W-1:0]    ld_fns;

   tod_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W),
      .FNS_W(FNS_W), .PER_NS_W(PER_NS_W), .RATE_W(RATE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .per_ns(per_ns), .per_fns(per_fns), .adj_ns(adj_ns), .adj_fns(adj_fns),
      .rate(rate), .rate_wr(rate_wr), .ld_commit(ld_commit),
      .ld_sec(ld_sec), .ld_ns(ld_ns), .ld_fns(ld_fns)
   );

   tod_interval_timer #(.RATE_W(RATE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .rate(rate),
      .restart(rate_wr | ld_commit), .fire(fire), .cnt(cnt)
   );

   tod_accum #(
      .SEC_W(SEC_W), .NS_W(NS_W), .FNS_W(FNS_W),
      .PER_NS_W(PER_NS_W), .NS_ROLLOVER(NS_ROLLOVER)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .load(ld_commit),
      .ld_sec(ld_sec), .ld_ns(ld_ns), .ld_fns(ld_fns),
      .per_ns(per_ns), .per_fns(per_fns), .adj_ns(adj_ns), .adj_fns(adj_fns),
      .fire(fire), .sec(tod_sec), .ns(tod_ns), .fns(tod_fns)
   );

endmodule

// File: rtl/tod_drift_counter_chk.sv
module tod_drift_counter_chk #(
   parameter int SEC_W       = 48,
   parameter int NS_W        = 30,
   parameter int FNS_W       = 16,
   parameter int PER_NS_W    = 4,
   parameter int RATE_W      = 16,
   parameter bit NS_ROLLOVER = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ld_commit,
   input logic                rate_wr,
   input logic                fire,
   input logic [RATE_W-1:0]   rate,
   input logic [RATE_W-1:0]   cnt,
   input logic [PER_NS_W-1:0] per_ns,
   input logic [FNS_W-1:0]    per_fns,
   input logic [NS_W-1:0]     wr_ns,
   input logic [SEC_W-1:0]    tod_sec,
   input logic [NS_W-1:0]     tod_ns,
   input logic [FNS_W-1:0]    tod_fns
);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_commit && per_ns == '0 && per_fns == '0 && !fire)
      |=> ($stable(tod_sec) && $stable(tod_ns) && $stable(tod_fns)));   // R1

   AST_ZERO_RATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == '0) |-> !fire);   // R4

   AST_FIRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rate > RATE_W'(1) && !rate_wr && !ld_commit) |=> !fire);   // R5

   AST_RATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      rate_wr |=> (cnt == '0));   // R6

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_commit |=> (tod_ns == $past(wr_ns) && cnt == '0));   // R9

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_commit |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 1'b1));   // R8

   generate
      if (NS_ROLLOVER) begin : g_ns_range
         AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_commit && tod_ns < NS_W'(1_000_000_000))
            |=> (tod_ns < NS_W'(1_000_000_000)));   // R8
      end
   endgenerate

endmodule

bind tod_drift_counter tod_drift_counter_chk #(
   .SEC_W(SEC_W), .NS_W(NS_W), .FNS_W(FNS_W), .PER_NS_W(PER_NS_W),
   .RATE_W(RATE_W), .NS_ROLLOVER(NS_ROLLOVER)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_commit(ld_commit), .rate_wr(rate_wr),
   .fire(fire), .rate(rate), .cnt(cnt), .per_ns(per_ns), .per_fns(per_fns),
   .wr_ns(reg_wdata[NS_W-1:0]), .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_fns(tod_fns)
);

// File: tb/test_tod_drift_counter.sv
`timescale 1ns/1ps
module test_tod_drift_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [47:0] tod_sec;
   logic [29:0] tod_ns;
   logic [15:0] tod_fns;

   always #2 clk = ~clk;   // 250 MHz

   tod_drift_counter i_tod_drift_counter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_fns(tod_fns)
   );

   typedef struct {
      logic [47:0] sec;
      logic [29:0] ns;
      logic [15:0] fns;
      string       tag;
   } exp_t;

   exp_t q[$];
   exp_t mon_e;
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;

   // Reference state built from the requirements
   logic [47:0] m_sec = '0;
   longint      m_ns = 0, m_fns = 0;
   longint      m_pns = 0, m_pfns = 0, m_ans = 0, m_afns = 0;
   longint      m_rate = 0, m_cnt = 0;
   logic [15:0] st_hi = '0;
   logic [31:0] st_lo = '0;
   logic [15:0] st_fns = '0;

   task automatic model_step(bit we, logic [5:0] a, logic [31:0] d);
      bit fire;
      longint f, n;
      if (we && a == 6'h08) begin
         m_sec = {st_hi, st_lo};
         m_ns  = longint'(d[29:0]);
         m_fns = longint'(st_fns);
         m_cnt = 0;
      end else begin
         fire = (m_rate != 0) && (m_cnt == m_rate - 1);
         if (m_rate == 0 || fire) m_cnt = 0;
         else m_cnt = m_cnt + 1;
         f = m_fns + m_pfns + (fire ? m_afns : 0);
         n = m_ns + m_pns + (fire ? m_ans : 0) + f / 65536;
         m_fns = f % 65536;
         if (n >= 1000000000) begin
            n = n - 1000000000;
            m_sec = m_sec + 1;
         end
         m_ns = n;
      end
      if (we) begin
         case (a)
            6'h00: st_hi  = d[15:0];
            6'h04: st_lo  = d;
            6'h0C: st_fns = d[15:0];
            6'h10: begin m_pns = longint'(d[19:16]); m_pfns = longint'(d[15:0]); end
            6'h1C: begin m_ans = longint'(d[19:16]); m_afns = longint'(d[15:0]); end
            6'h20: begin m_rate = longint'(d[15:0]); m_cnt = 0; end
            default: ;
         endcase
      end
   endtask

   // Driver: one clock edge with optional write, expected result queued
   task automatic tick(bit we, logic [5:0] a, logic [31:0] d, string tag);
      exp_t e;
      reg_wr    = we;
      reg_addr  = a;
      reg_wdata = d;
      @(posedge clk);
      model_step(we, a, d);
      e.sec = m_sec; e.ns = m_ns[29:0]; e.fns = m_fns[15:0]; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) tick(1'b0, 6'h3C, 32'h0, tag);
   endtask

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string tag);
      reg_wr   = 1'b0;
      reg_addr = a;
      #1;
      check(tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic load_time(logic [47:0] s, logic [29:0] n, logic [15:0] f, string tag);
      tick(1'b1, 6'h00, {16'h0, s[47:32]}, tag);
      tick(1'b1, 6'h04, s[31:0], tag);
      tick(1'b1, 6'h0C, {16'h0, f}, tag);
      tick(1'b1, 6'h08, {2'b0, n}, tag);
   endtask

   // Monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         mon_e = q.pop_front();
         n_tests++;
         if (tod_sec !== mon_e.sec || tod_ns !== mon_e.ns || tod_fns !== mon_e.fns) begin
            n_fail++;
            $display("FAIL %s: actual %0d s %0d ns 0x%04h expected %0d s %0d ns 0x%04h",
                     mon_e.tag, tod_sec, tod_ns, tod_fns, mon_e.sec, mon_e.ns, mon_e.fns);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset time", {tod_sec[15:0], 18'(tod_ns), tod_fns}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(6'h10, 32'h0, "R1 period reset");
      rd_chk(6'h1C, 32'h0, "R1 drift reset");
      rd_chk(6'h20, 32'h0, "R1 rate reset");
      idle(4, "R1 no advance with zero period");

      // R2/R3/R4: field masking on read back, R9 staging reads zero
      tick(1'b1, 6'h10, 32'hABCD_1234, "R2 period write");
      rd_chk(6'h10, 32'h000D_1234, "R2 period readback");
      tick(1'b1, 6'h1C, 32'hFFFF_FFFF, "R3 drift write");
      rd_chk(6'h1C, 32'h000F_FFFF, "R3 drift readback");
      tick(1'b1, 6'h20, 32'hFFFF_0005, "R4 rate write");
      rd_chk(6'h20, 32'h0000_0005, "R4 rate readback");
      tick(1'b1, 6'h04, 32'h1234_5678, "R9 stage write");
      rd_chk(6'h04, 32'h0, "R9 staging reads zero");

      // R10: 6.4 ns period with correction every 5 cycles
      tick(1'b1, 6'h10, 32'h0006_6666, "R10 period");
      tick(1'b1, 6'h1C, 32'h0000_0002, "R10 drift");
      tick(1'b1, 6'h20, 32'h0000_0005, "R10 rate");
      load_time(48'h0, 30'd0, 16'h0, "R9 load zero");
      idle(100, "R10 R5 R7 running");
      check("R10 ns after 100 cycles", 64'(tod_ns), 64'd640);
      check("R10 fraction after 100 cycles", 64'(tod_fns), 64'h0);
      idle(3, "R10 partial interval");

      // R8: double carry into ns and billion rollover with correction
      tick(1'b1, 6'h10, 32'h000F_FFFF, "R8 period");
      tick(1'b1, 6'h1C, 32'h000F_FFFF, "R8 drift");
      tick(1'b1, 6'h20, 32'h0000_0001, "R8 rate");
      load_time(48'h0001_0000_0005, 30'd999_999_990, 16'hFFFF, "R9 load near rollover");
      check("R9 loaded seconds", 64'(tod_sec), 64'h0001_0000_0005);
      idle(1, "R8 rollover");
      check("R8 seconds after rollover", 64'(tod_sec), 64'h0001_0000_0006);
      check("R8 ns after rollover", 64'(tod_ns), 64'd22);
      check("R7 fraction double carry", 64'(tod_fns), 64'hFFFD);
      idle(5, "R8 after rollover");

      // R6: rewriting the same interval restarts the count
      tick(1'b1, 6'h10, 32'h0001_0000, "R6 period 1ns");
      tick(1'b1, 6'h1C, 32'h0000_0100, "R6 drift");
      tick(1'b1, 6'h20, 32'h0000_0004, "R6 rate");
      load_time(48'h0, 30'd0, 16'h0, "R9 load zero");
      idle(2, "R6 before rewrite");
      tick(1'b1, 6'h20, 32'h0000_0004, "R6 rewrite rate");
      idle(3, "R6 after rewrite");
      check("R6 no correction yet", 64'(tod_fns), 64'h0);
      idle(1, "R6 first correction");
      check("R5 correction on 4th cycle", 64'(tod_fns), 64'h0100);
      check("R5 period still added", 64'(tod_ns), 64'd7);

      // R4: zero interval never corrects
      tick(1'b1, 6'h1C, 32'h0005_0000, "R4 big drift");
      tick(1'b1, 6'h20, 32'h0000_0000, "R4 rate zero");
      load_time(48'h0, 30'd0, 16'h0, "R9 load zero");
      idle(10, "R4 no correction");
      check("R4 ns with zero rate", 64'(tod_ns), 64'd10);

      // R9: load overrides the increment mid-run
      tick(1'b1, 6'h20, 32'h0000_0003, "R9 rate");
      idle(2, "R9 running");
      load_time(48'h0000_0000_0042, 30'd123_456_789, 16'h8000, "R9 load mid run");
      check("R9 loaded ns exact", 64'(tod_ns), 64'd123_456_789);
      idle(6, "R9 after load");

      @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule